// File: doc/BRIEF.md
# Programmable One-Shot Delay Timer

This block measures a programmable delay in system clock cycles after a trigger and then raises a latched completion flag. The delay is a count loaded at run time. With a wide counter the delay reaches well into the millisecond range: 26 bits cover about one second at 50 MHz. The flag stays set until an active-low clear is applied. A busy output shows that a delay is in progress. All logic runs on one clock. The end-of-delay condition is always captured in a flip-flop on that clock before it reaches the flag, so no combinational compare or carry result ever acts as a clock or drives the output directly.

The counting style is chosen by a parameter. One style counts up from zero and compares the count for equality against a latched compare value. The other presets a down-counter and detects zero. In both styles the registered detection adds one cycle of latency, so the value loaded into the counter or compare register is one less than the programmed delay. Both styles produce the same timing at the ports. The trigger is used on its rising edge, which is detected on the same clock. A trigger that arrives while a delay is running is ignored.

Top module: `ost_timer`

## Requirements
- R1: After reset, `done` and `busy` are 0. A `trig` that is already high when reset is released does not count as an edge.
- R2: A clock edge that samples `trig` high, when the previous edge sampled it low and `busy` is 0, accepts a trigger. `busy` is 1 from that edge onward.
- R3: For a programmed delay N ≥ 1, `done` rises at the (N+1)-th clock edge after the accepting edge. `busy` falls at the same edge. `done` stays 0 at every earlier edge.
- R4: A programmed delay of 0 sets `done` at the first clock edge after the accepting edge, with no counter wraparound.
- R5: `delay` is sampled only at the accepting edge. Later changes to it have no effect on the running delay.
- R6: A rising edge of `trig` while `busy` is 1 is ignored and does not restart or stretch the delay.
- R7: Once set, `done` stays 1 for as long as `clr_n` is 1. The clear is synchronous: `clr_n` low at an edge makes `done` 0 after that edge, and the clear takes priority over a completion at the same edge.
- R8: After completion the counter holds. `busy` stays 0 and no further completion occurs until a new rising edge of `trig`, even if `trig` stays high.
- R9: The largest delay, 2^CNT_W − 1, completes at edge 2^CNT_W without wrapping early.
- R10: The parameter `STYLE` selects an up-counter with an equality compare (`CNT_UP`) or a preset down-counter with zero detection (`CNT_DOWN`). Both give identical port timing.
- R11: The internal terminal indication is a registered pulse. It is one cycle wide and occurs only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear of `done`, active low |
| trig | input | 1 | Trigger; its rising edge starts a delay |
| delay | input | CNT_W | Programmed delay in clock cycles |
| done | output | 1 | Latched completion flag |
| busy | output | 1 | A delay is in progress |

## Verification
The bench builds two instances with `CNT_W` set to 12: one with `STYLE` = `CNT_UP` and one with `CNT_DOWN`. Both are driven by the same stimulus and are expected to agree cycle for cycle. The narrow counter puts the full-range delay of 4095 cycles within reach, so the bench can check that it completes without wraparound. A table of delays from 0 to 1000 checks the exact completion edge and that `done` is never set early. Directed tests cover a trigger held high through reset, a retrigger and a delay change in mid-run, clearing, and a trigger held high after completion.

// File: rtl/ost_pkg.sv
package ost_pkg;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_style_e;

    typedef struct packed {
        logic busy;
        logic done;
    } ctl_state_t;

endpackage

// File: rtl/ost_edge.sv
module ost_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig;
    end

    // prev starts high so a level already present at reset is not an edge
    always_ff @(posedge clk) begin
        if (rst) st_q.prev <= 1'b1;
        else     st_q      <= st_d;
    end

    assign rise = sig & ~st_q.prev;
endmodule

// File: rtl/ost_cnt_up.sv
module ost_cnt_up #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] delay,
    input  logic             run,
    output logic             term
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             term;
    } up_state_t;

    up_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (load) begin
            st_d.cnt  = '0;
            // one cycle is taken back for the registered match
            st_d.cmp  = delay - CNT_W'(1);
            st_d.term = (delay == '0);
        end else if (run) begin
            st_d.term = (st_q.cnt == st_q.cmp);
            if (st_q.cnt != st_q.cmp) st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign term = st_q.term;
endmodule

// File: rtl/ost_cnt_down.sv
module ost_cnt_down #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] delay,
    input  logic             run,
    output logic             term
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             term;
    } dn_state_t;

    dn_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (load) begin
            // preset one below the delay to cover the registered zero flag
            st_d.cnt  = delay - CNT_W'(1);
            st_d.term = (delay == '0);
        end else if (run) begin
            st_d.term = (st_q.cnt == '0);
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign term = st_q.term;
endmodule

// File: rtl/ost_timer.sv
module ost_timer #(
    parameter int                  CNT_W = 26,
    parameter ost_pkg::cnt_style_e STYLE = ost_pkg::CNT_UP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] delay,
    output logic             done,
    output logic             busy
);
    import ost_pkg::*;

    logic       rise;
    logic       accept;
    logic       run;
    logic       term;
    ctl_state_t st_d, st_q;

    ost_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (trig),
        .rise (rise)
    );

    generate
        if (STYLE == CNT_DOWN) begin : g_down
            ost_cnt_down #(.CNT_W(CNT_W)) u_cnt (
                .clk (clk), .rst (rst), .load (accept),
                .delay (delay), .run (run), .term (term)
            );
        end else begin : g_up
            ost_cnt_up #(.CNT_W(CNT_W)) u_cnt (
                .clk (clk), .rst (rst), .load (accept),
                .delay (delay), .run (run), .term (term)
            );
        end
    endgenerate

    assign accept = rise & ~st_q.busy;
    assign run    = st_q.busy & ~term;

    always_comb begin
        st_d = st_q;
        if (accept)    st_d.busy = 1'b1;
        else if (term) st_d.busy = 1'b0;
        // flag acts as a set-only flop; the clear wins
        if (!clr_n)    st_d.done = 1'b0;
        else if (term) st_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done = st_q.done;
    assign busy = st_q.busy;
endmodule

// File: rtl/ost_timer_chk.sv
module ost_timer_chk (
    input logic clk,
    input logic rst,
    input logic clr_n,
    input logic trig,
    input logic busy,
    input logic done,
    input logic term
);
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    // R3
    busy_end_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || !$past(clr_n)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && clr_n) |=> done);

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> !done);

    // R11
    term_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        term |=> !term);

    // R11
    term_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        term |-> busy);
endmodule

bind ost_timer ost_timer_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .trig  (trig),
    .busy  (busy),
    .done  (done),
    .term  (term)
);

// File: tb/tb_ost_timer.sv
module tb_ost_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 12;
    localparam int NV         = 8;
    localparam int DELAYS [NV] = '{0, 1, 2, 3, 7, 25, 100, 1000};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_n = 1'b1;
    logic          trig = 1'b0;
    logic [CW-1:0] dly = '0;
    logic          done_u, busy_u, done_d, busy_d;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ost_timer #(.CNT_W(CW), .STYLE(ost_pkg::CNT_UP)) dut (
        .clk (clk), .rst (rst), .clr_n (clr_n), .trig (trig),
        .delay (dly), .done (done_u), .busy (busy_u)
    );

    ost_timer #(.CNT_W(CW), .STYLE(ost_pkg::CNT_DOWN)) dut_dn (
        .clk (clk), .rst (rst), .clr_n (clr_n), .trig (trig),
        .delay (dly), .done (done_d), .busy (busy_d)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_done();
        clr_n = 1'b0;
        tick();
        clr_n = 1'b1;
    endtask

    // trigger with delay n; check busy at accept, no early done, exact completion
    task automatic fire(input int n, input string req);
        int early = 0;
        trig = 1'b1;
        dly  = CW'(n);
        tick();
        trig = 1'b0;
        chk(req, "busy at accept (both styles)", {busy_u, busy_d}, 3);
        chk(req, "done at accept", {done_u, done_d}, 0);
        for (int k = 1; k <= n; k++) begin
            tick();
            if (done_u || done_d || !busy_u || !busy_d) early++;
        end
        chk(req, $sformatf("early done/busy loss, N=%0d", n), early, 0);
        tick();
        chk(req, $sformatf("done at edge N+1, N=%0d", n), {done_u, done_d}, 3);
        chk(req, $sformatf("busy low at completion, N=%0d", n), {busy_u, busy_d}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: trigger held high through reset release
        trig = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "done after reset", {done_u, done_d}, 0);
        chk("R1", "busy after reset", {busy_u, busy_d}, 0);
        repeat (4) tick();
        chk("R1", "level at reset not an edge", {busy_u, busy_d}, 0);
        trig = 1'b0;
        tick();

        // R3 R4 R10: table of delays, both styles compared
        for (int i = 0; i < NV; i++) begin
            clear_done();
            fire(DELAYS[i], DELAYS[i] == 0 ? "R4" : "R3");
        end

        // R7: done holds while clr_n high, then clears
        repeat (20) tick();
        chk("R7", "done held", {done_u, done_d}, 3);
        clear_done();
        chk("R7", "done cleared", {done_u, done_d}, 0);

        // R2 R5 R6: delay 10, delay input changed and retrigger in mid-run
        trig = 1'b1;
        dly  = CW'(10);
        tick();
        trig = 1'b0;
        chk("R2", "busy after edge", {busy_u, busy_d}, 3);
        begin
            int early = 0;
            for (int k = 1; k <= 10; k++) begin
                if (k == 2) dly = CW'(2);
                if (k == 4) trig = 1'b1;
                if (k == 5) trig = 1'b0;
                tick();
                if (done_u || done_d) early++;
            end
            chk("R5", "delay change had no effect (no early done)", early, 0);
            tick();
            chk("R6", "retrigger ignored, done at edge 11", {done_u, done_d}, 3);
            repeat (12) tick();
            chk("R6", "no restarted run after completion", {busy_u, busy_d}, 0);
        end

        // R8: trigger held high after completion does not restart
        clear_done();
        trig = 1'b1;
        dly  = CW'(3);
        tick();
        repeat (10) tick();
        chk("R8", "done once with trig held", {done_u, done_d}, 3);
        clear_done();
        repeat (10) tick();
        chk("R8", "no second done while trig held", {done_u, done_d}, 0);
        chk("R8", "busy stays low while trig held", {busy_u, busy_d}, 0);
        trig = 1'b0;
        tick();

        // R9: full-range delay
        fire((1 << CW) - 1, "R9");
        clear_done();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule